// File: doc/BRIEF.md
# Four-channel transceiver management register bank

This block holds the management-visible control state of a four-channel serial transceiver. It sits behind a management frame engine that has already decoded each Clause 22 access into a PHY address, a register address, write data and read/write strobes, all in the management clock domain. The low bits of the PHY address pick which channel's copy of the basic control register is reached. Two register addresses instead reach a single pair of global registers, so every channel sees the same contents there.

Each channel's control register drives four per-channel outputs toward the datapath: loopback, power-down, isolate and a one-cycle channel reset. The loopback output also follows an external per-channel loopback pin. The speed, duplex and auto-negotiation fields are hard-wired to the only operating point the transceiver supports. Writes to those fields are discarded. All accesses are gated by a mode-select input, and nothing is accepted while it is low.

Top module: `mgmt_regbank`

## Requirements
- R1: After reset, register 0 of every channel reads 0x0140, registers 30 and 31 read 0x0000, rd_data is 0x0000 and all of loop_out, pdown_out, isolate_out and chan_rst are 0.
- R2: While mode_c22 is 0, writes change no register and reads leave rd_data unchanged.
- R3: phy_addr[1:0] selects the channel (00 selects channel 0, 01 channel 1, 10 channel 2, 11 channel 3). phy_addr[4:2] is ignored.
- R4: Registers 30 and 31 are single shared 16-bit read/write registers. A write through any channel address is returned by a read through any other channel address.
- R5: An accepted read (rd_en=1 with mode_c22=1 at a rising edge) presents the addressed value on rd_data after that edge. rd_data then holds until the next accepted read.
- R6: Writing 1 to bit 15 of register 0 raises that channel's chan_rst for exactly one cycle after the write. At the end of that cycle the channel's register 0 returns to 0x0140 and its outputs return to 0. The other channels and registers 30/31 are unaffected.
- R7: loop_out[i] is the OR of register-0 bit 14 of channel i and ext_loop[i].
- R8: In register 0, bits 13, 12, 9 and 7 read 0, bits 8 and 6 read 1, and bits 5..0 read 0, whatever is written. Writing 0x7FFF reads back 0x4D40, and writing 0x0000 reads back 0x0140.
- R9: Register-0 bit 11 drives pdown_out and bit 10 drives isolate_out for that channel. Register access to a powered-down channel keeps working.
- R10: Reads of any register address other than 0, 30 and 31 return 0x0000. Writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_c22 | input | 1 | Mode select; accesses are accepted only while 1 |
| phy_addr | input | 5 | Decoded PHY address; low two bits pick the channel |
| reg_addr | input | 5 | Decoded register address |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 16 | Registered read data |
| ext_loop | input | 4 | External per-channel loopback pins |
| loop_out | output | 4 | Per-channel loopback enable to the datapath |
| pdown_out | output | 4 | Per-channel power-down |
| isolate_out | output | 4 | Per-channel isolate |
| chan_rst | output | 4 | Per-channel one-cycle reset pulse |

## Verification
The bench writes all ones (except the reset bit) to register 0 and expects only the writable bits to come back. A design that stored the fixed fields would return 0x7FFF instead of 0x4D40. It reaches channels with the upper PHY address bits set and checks the shared registers across different channel addresses. A full-width channel decode or per-channel global copies would read back the wrong value there. A channel reset is fired on a channel that has power-down set, and the bench checks that the pulse lasts one cycle and that the other channel and the globals keep their contents. Accesses with mode-select low, and writes to an unimplemented address, must leave both the registers and rd_data untouched.

// File: rtl/mgmt_regbank_pkg.sv
package mgmt_regbank_pkg;
    localparam int DW = 16;
    localparam logic [DW-1:0] CTRL_DEFAULT = 16'h0140;

    typedef struct packed {
        logic rst;
        logic loop;
        logic pdown;
        logic iso;
    } chan_ctrl_t;

    typedef struct packed {
        logic [DW-1:0] g0;
        logic [DW-1:0] g1;
    } glob_t;

    typedef struct packed {
        logic [DW-1:0] rd_data;
    } top_t;

    function automatic logic [DW-1:0] ctrl_word(input chan_ctrl_t c);
        logic [DW-1:0] w;
        w      = CTRL_DEFAULT;
        w[15]  = c.rst;
        w[14]  = c.loop;
        w[11]  = c.pdown;
        w[10]  = c.iso;
        return w;
    endfunction
endpackage

// File: rtl/mgmt_chan_ctrl.sv
module mgmt_chan_ctrl
    import mgmt_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          ext_loop,
    output logic [DW-1:0] word,
    output logic          loop_out,
    output logic          pdown_out,
    output logic          iso_out,
    output logic          rst_out
);
    chan_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_q.rst) begin
            ctrl_d = '0;
        end else if (wr) begin
            ctrl_d.rst   = wdata[15];
            ctrl_d.loop  = wdata[14];
            ctrl_d.pdown = wdata[11];
            ctrl_d.iso   = wdata[10];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign word      = ctrl_word(ctrl_q);
    assign loop_out  = ctrl_q.loop | ext_loop;
    assign pdown_out = ctrl_q.pdown;
    assign iso_out   = ctrl_q.iso;
    assign rst_out   = ctrl_q.rst;

    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !rst_out);

    // R6
    rst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> (word == CTRL_DEFAULT));

    // R7
    ext_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_loop |-> loop_out);
endmodule

// File: rtl/mgmt_global_regs.sv
module mgmt_global_regs
    import mgmt_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr0,
    input  logic          wr1,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] g0,
    output logic [DW-1:0] g1
);
    glob_t glob_d, glob_q;

    always_comb begin
        glob_d = glob_q;
        if (wr0) glob_d.g0 = wdata;
        if (wr1) glob_d.g1 = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) glob_q <= '0;
        else        glob_q <= glob_d;
    end

    assign g0 = glob_q.g0;
    assign g1 = glob_q.g1;

    // R4
    g0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr0 |=> $stable(g0));

    // R4
    g1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr1 |=> $stable(g1));
endmodule

// File: rtl/mgmt_regbank.sv
module mgmt_regbank
    import mgmt_regbank_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int AW    = 5,
    parameter int GADR0 = 30,
    parameter int GADR1 = 31
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_c22,
    input  logic [AW-1:0]  phy_addr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           wr_en,
    input  logic           rd_en,
    output logic [DW-1:0]  rd_data,
    input  logic [NCH-1:0] ext_loop,
    output logic [NCH-1:0] loop_out,
    output logic [NCH-1:0] pdown_out,
    output logic [NCH-1:0] isolate_out,
    output logic [NCH-1:0] chan_rst
);
    localparam int CSW = $clog2(NCH);

    logic [CSW-1:0] ch_sel;
    logic           wr_ok, rd_ok;
    logic           hit_ctrl, hit_g0, hit_g1;
    logic [DW-1:0]  words [NCH];
    logic [DW-1:0]  g0, g1;
    top_t           top_d, top_q;

    assign ch_sel   = phy_addr[CSW-1:0];
    assign wr_ok    = mode_c22 & wr_en;
    assign rd_ok    = mode_c22 & rd_en;
    assign hit_ctrl = (reg_addr == AW'(0));
    assign hit_g0   = (reg_addr == AW'(GADR0));
    assign hit_g1   = (reg_addr == AW'(GADR1));

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        mgmt_chan_ctrl u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_ok && hit_ctrl && (ch_sel == CSW'(i))),
            .wdata    (wr_data),
            .ext_loop (ext_loop[i]),
            .word     (words[i]),
            .loop_out (loop_out[i]),
            .pdown_out(pdown_out[i]),
            .iso_out  (isolate_out[i]),
            .rst_out  (chan_rst[i])
        );
    end

    mgmt_global_regs u_glob (
        .clk  (clk),
        .rst_n(rst_n),
        .wr0  (wr_ok && hit_g0),
        .wr1  (wr_ok && hit_g1),
        .wdata(wr_data),
        .g0   (g0),
        .g1   (g1)
    );

    always_comb begin
        top_d = top_q;
        if (rd_ok) begin
            if (hit_ctrl)    top_d.rd_data = words[ch_sel];
            else if (hit_g0) top_d.rd_data = g0;
            else if (hit_g1) top_d.rd_data = g1;
            else             top_d.rd_data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rd_data = top_q.rd_data;

    // R2
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |=> $stable(rd_data));

    // R2
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_c22 |=> ($stable(g0) && $stable(g1)));

    // R6
    one_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_rst));
endmodule

// File: tb/tb_mgmt_regbank.sv
module tb_mgmt_regbank;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        mode_c22 = 0;
    logic [4:0]  phy_addr = 0;
    logic [4:0]  reg_addr = 0;
    logic [15:0] wr_data = 0;
    logic        wr_en = 0;
    logic        rd_en = 0;
    logic [15:0] rd_data;
    logic [3:0]  ext_loop = 0;
    logic [3:0]  loop_out, pdown_out, isolate_out, chan_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mgmt_regbank dut (
        .clk(clk), .rst_n(rst_n), .mode_c22(mode_c22),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .ext_loop(ext_loop), .loop_out(loop_out), .pdown_out(pdown_out),
        .isolate_out(isolate_out), .chan_rst(chan_rst)
    );

    // vector: {is_read, mode, phy[4:0], reg[4:0], wdata[15:0], expect[15:0]}
    localparam int NV = 16;
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 1'b1, 5'd0,  5'd0,  16'h7FFF, 16'h0000},
        {1'b1, 1'b1, 5'd0,  5'd0,  16'h0000, 16'h4D40}, // R8
        {1'b1, 1'b1, 5'd1,  5'd0,  16'h0000, 16'h0140}, // R3
        {1'b0, 1'b1, 5'd6,  5'd0,  16'h0800, 16'h0000},
        {1'b1, 1'b1, 5'd2,  5'd0,  16'h0000, 16'h0940}, // R3 R9
        {1'b0, 1'b1, 5'd3,  5'd30, 16'hA5A5, 16'h0000},
        {1'b1, 1'b1, 5'd0,  5'd30, 16'h0000, 16'hA5A5}, // R4
        {1'b0, 1'b1, 5'd1,  5'd31, 16'h1234, 16'h0000},
        {1'b1, 1'b1, 5'd2,  5'd31, 16'h0000, 16'h1234}, // R4
        {1'b0, 1'b0, 5'd3,  5'd0,  16'h4000, 16'h0000},
        {1'b1, 1'b1, 5'd3,  5'd0,  16'h0000, 16'h0140}, // R2
        {1'b0, 1'b1, 5'd1,  5'd5,  16'hFFFF, 16'h0000},
        {1'b1, 1'b1, 5'd1,  5'd5,  16'h0000, 16'h0000}, // R10
        {1'b1, 1'b1, 5'd1,  5'd0,  16'h0000, 16'h0140}, // R10
        {1'b0, 1'b0, 5'd0,  5'd30, 16'h0000, 16'h0000},
        {1'b1, 1'b1, 5'd1,  5'd30, 16'h0000, 16'hA5A5}  // R2
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic m, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd);
        @(negedge clk);
        mode_c22 = m; phy_addr = pa; reg_addr = ra; wr_data = wd;
        wr_en = !rd; rd_en = rd;
        @(negedge clk);
        wr_en = 0; rd_en = 0; mode_c22 = 1;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] exp);
        access(1'b1, 1'b1, pa, ra, 16'h0);
        chk(req, rd_data, exp);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        mode_c22 = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 outputs", {loop_out, pdown_out, isolate_out, chan_rst}, 16'h0000);
        for (int c = 0; c < 4; c++) rd_chk("R1 ctrl", 5'(c), 5'd0, 16'h0140);
        rd_chk("R1 g30", 5'd0, 5'd30, 16'h0000);
        rd_chk("R1 g31", 5'd0, 5'd31, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            access(VEC[v][43], VEC[v][42], VEC[v][41:37], VEC[v][36:32], VEC[v][31:16]);
            if (VEC[v][43]) begin
                checks++;
                if (rd_data !== VEC[v][15:0]) begin
                    errors++;
                    $display("FAIL vector %0d: actual %h expected %h", v, rd_data, VEC[v][15:0]);
                end
            end
        end

        // R9 outputs: ch0 has pdown+iso+loop, ch2 pdown only
        chk("R9 pdown", {12'h0, pdown_out}, 16'h0005);
        chk("R9 isolate", {12'h0, isolate_out}, 16'h0001);
        chk("R7 loop reg", {12'h0, loop_out}, 16'h0001);

        // R7 external pin OR
        @(negedge clk); ext_loop = 4'b1000;
        @(negedge clk);
        chk("R7 loop pin", {12'h0, loop_out}, 16'h0009);
        ext_loop = 0;

        // R5 hold, R2 gated read
        rd_chk("R5 read", 5'd3, 5'd31, 16'h1234);
        repeat (3) @(negedge clk);
        chk("R5 hold", rd_data, 16'h1234);
        access(1'b1, 1'b0, 5'd0, 5'd30, 16'h0);
        chk("R2 gated read", rd_data, 16'h1234);

        // R6 reset pulse on ch2 (powered down), loop set in same write
        access(1'b0, 1'b1, 5'd2, 5'd0, 16'hC000);
        chk("R6 pulse high", {12'h0, chan_rst}, 16'h0004);
        chk("R6 loop during", {12'h0, loop_out}, 16'h0005);
        @(negedge clk);
        chk("R6 pulse low", {12'h0, chan_rst}, 16'h0000);
        chk("R6 pdown cleared", {12'h0, pdown_out}, 16'h0001);
        chk("R6 loop cleared", {12'h0, loop_out}, 16'h0001);
        rd_chk("R6 ch2 default", 5'd2, 5'd0, 16'h0140);
        rd_chk("R6 ch0 kept", 5'd0, 5'd0, 16'h4D40);
        rd_chk("R6 g30 kept", 5'd1, 5'd30, 16'hA5A5);

        // R8 write zero reads default; R9 powered-down channel still accessible
        access(1'b0, 1'b1, 5'd0, 5'd0, 16'h0000);
        rd_chk("R8 zero write", 5'd0, 5'd0, 16'h0140);
        chk("R9 cleared", {12'h0, pdown_out}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule